// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

A purely combinational integer arithmetic-logic unit built by replicating one identical single-bit slice across the operand width, which is 32 bits by default. Each slice holds an AND gate, an OR gate, a full adder, optional inversion of either operand and a four-way result selector. The carry ripples from bit 0 to the top bit. A 4-bit operation code picks between AND, OR, NOR, add, subtract and signed set-on-less-than. The block reports a zero flag, a signed-overflow flag and a carry-out next to the result.

The operation code is decoded by field. Bit 3 inverts A in every slice. Bit 2 inverts B in every slice and also supplies the carry into bit 0, so subtraction is A + ~B + 1. Bits 1:0 pick the slice output. NOR is the AND path with both operands inverted. For set-on-less-than, the top slice's adder sign, corrected by the overflow condition, is routed back into the selectable "less" input of bit 0. All other slices see 0 on that input.

Top module: `bs_alu`

## Requirements
- R1: Operation code 0000 gives result = A AND B.
- R2: Operation code 0001 gives result = A OR B.
- R3: Operation code 0010 gives result = (A + B) mod 2^WIDTH, and carry_o is the carry out of the top bit.
- R4: Operation code 0110 gives result = (A - B) mod 2^WIDTH, computed as A + ~B + 1. carry_o is the carry out of the top bit, which is 1 exactly when A >= B unsigned.
- R5: Operation code 0111 gives result 1 when A < B as signed two's-complement numbers and 0 otherwise. This holds even when A - B overflows. All result bits above bit 0 are 0.
- R6: Operation code 1100 gives result = NOT (A OR B).
- R7: For add and subtract, ovf_o is 1 exactly when the signed result does not fit. This happens when both addends, after B is negated for subtract, have the same sign and the sum's sign differs from it. Adding operands of opposite sign never sets ovf_o.
- R8: For AND, OR, NOR and set-on-less-than, ovf_o and carry_o are both 0.
- R9: zero_o is 1 exactly when every result bit is 0, for every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 4 | Operation code: bit 3 inverts A, bit 2 negates B, bits 1:0 select the slice output |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow, add and subtract only |
| carry_o | output | 1 | Carry out of the top bit, add and subtract only |

## Verification
A 4-bit instance is swept over every operand pair under all six operation codes. This covers every sign combination, both directions of overflow and every equal or adjacent comparison for set-on-less-than. Among these cases, the overflowing comparisons are the ones that separate a corrected sign from the raw adder sign. A 32-bit instance is driven with all pairings of zero, all ones, the largest positive value and the most negative value. Those pairings exercise the full ripple length and the extreme overflow cases. Random operand pairs are then added to catch wiring faults in the slices and the carry chain.

// File: rtl/bs_alu_pkg.sv
package bs_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } slice_sel_e;

  typedef struct packed {
    logic       a_inv;
    logic       b_neg;
    slice_sel_e sel;
  } slice_ctrl_t;
endpackage

// File: rtl/bs_alu_dec.sv
module bs_alu_dec
  import bs_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output slice_ctrl_t     ctrl_o
);
  always_comb begin
    ctrl_o.a_inv = op_i[3];
    ctrl_o.b_neg = op_i[2];
    ctrl_o.sel   = slice_sel_e'(op_i[1:0]);
  end
endmodule

// File: rtl/bs_alu_slice.sv
module bs_alu_slice
  import bs_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       a_inv_i,
  input  logic       b_neg_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       sum_o,
  output logic       cout_o
);
  logic a_x, b_x;

  always_comb begin
    a_x    = a_i ^ a_inv_i;
    b_x    = b_i ^ b_neg_i;
    sum_o  = a_x ^ b_x ^ cin_i;
    cout_o = (a_x & b_x) | (a_x & cin_i) | (b_x & cin_i);
    unique case (sel_i)
      SEL_AND: res_o = a_x & b_x;
      SEL_OR:  res_o = a_x | b_x;
      SEL_SUM: res_o = sum_o;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/bs_alu_flags.sv
module bs_alu_flags
  import bs_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] result_i,
  input  logic             c_msb_in_i,
  input  logic             c_msb_out_i,
  input  logic             sum_msb_i,
  input  slice_sel_e       sel_i,
  output logic             set_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             carry_o
);
  logic ovf_raw, arith;

  always_comb begin
    ovf_raw = c_msb_in_i ^ c_msb_out_i;
    arith   = (sel_i == SEL_SUM);
    // sign of the true difference, valid even when it overflows
    set_o   = sum_msb_i ^ ovf_raw;
    zero_o  = ~|result_i;
    ovf_o   = arith & ovf_raw;
    carry_o = arith & c_msb_out_i;
  end
endmodule

// File: rtl/bs_alu.sv
module bs_alu
  import bs_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             carry_o
);
  localparam int unsigned MSB = WIDTH - 1;

  slice_ctrl_t      ctrl;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] less;
  logic             set_fb;

  bs_alu_dec u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign carry[0] = ctrl.b_neg;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      if (i == 0) begin : g_lsb
        assign less[i] = set_fb;
      end else begin : g_mid
        assign less[i] = 1'b0;
      end

      bs_alu_slice u_slice (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .a_inv_i (ctrl.a_inv),
        .b_neg_i (ctrl.b_neg),
        .cin_i   (carry[i]),
        .less_i  (less[i]),
        .sel_i   (ctrl.sel),
        .res_o   (result_o[i]),
        .sum_o   (sum[i]),
        .cout_o  (carry[i+1])
      );
    end
  endgenerate

  bs_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .result_i    (result_o),
    .c_msb_in_i  (carry[MSB]),
    .c_msb_out_i (carry[WIDTH]),
    .sum_msb_i   (sum[MSB]),
    .sel_i       (ctrl.sel),
    .set_o       (set_fb),
    .zero_o      (zero_o),
    .ovf_o       (ovf_o),
    .carry_o     (carry_o)
  );
endmodule

// File: rtl/bs_alu_chk.sv
module bs_alu_chk
  import bs_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o,
  input logic             carry_o
);
  always_comb begin
    p_and_r1: assert (op_i != OP_AND || result_o == (a_i & b_i))
      else $error("and result mismatch");
    p_nor_r6: assert (op_i != OP_NOR || result_o == ~(a_i | b_i))
      else $error("nor result mismatch");
    p_slt_upper_r5: assert (op_i != OP_SLT || result_o[WIDTH-1:1] == '0)
      else $error("slt upper bits set");
    p_no_overflow_r7: assert (op_i != OP_ADD || a_i[WIDTH-1] == b_i[WIDTH-1] || !ovf_o)
      else $error("overflow on opposite-sign add");
    p_logic_flags_r8: assert (op_i[1:0] == 2'b10 || (!ovf_o && !carry_o))
      else $error("flag set on non-arithmetic op");
    p_zero_flag_r9: assert (zero_o == (result_o == '0))
      else $error("zero flag mismatch");
  end
endmodule

bind bs_alu bs_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .op_i     (op_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o),
  .carry_o  (carry_o)
);

// File: tb/bs_alu_bench.sv
module bs_alu_bench;
  localparam int unsigned SW = 4;
  localparam int unsigned LW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [SW-1:0] sa, sb, sres;
  logic [3:0]    sop;
  logic          sz, sv, sc;
  logic [LW-1:0] la, lb, lres;
  logic [3:0]    lop;
  logic          lz, lv, lc;

  bs_alu #(.WIDTH(SW)) u_bs_alu (
    .a_i(sa), .b_i(sb), .op_i(sop),
    .result_o(sres), .zero_o(sz), .ovf_o(sv), .carry_o(sc)
  );

  bs_alu #(.WIDTH(LW)) u_bs_alu_w32 (
    .a_i(la), .b_i(lb), .op_i(lop),
    .result_o(lres), .zero_o(lz), .ovf_o(lv), .carry_o(lc)
  );

  function automatic logic [3:0] op_code(input int k);
    case (k)
      0: return 4'b0000;
      1: return 4'b0001;
      2: return 4'b0010;
      3: return 4'b0110;
      4: return 4'b0111;
      default: return 4'b1100;
    endcase
  endfunction

  function automatic string op_req(input logic [3:0] op);
    case (op)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      default: return "R6";
    endcase
  endfunction

  // returns {carry, ovf, zero, result[31:0]}
  function automatic logic [34:0] ref_alu(input logic [3:0] op, input longint a,
                                          input longint b, input int w);
    longint mask, msb, s, r, sa_s, sb_s;
    logic cy, ov;
    mask = (64'sd1 <<< w) - 1;
    msb  = 64'sd1 <<< (w - 1);
    cy = 1'b0; ov = 1'b0; r = 0;
    case (op)
      4'b0000: r = a & b;
      4'b0001: r = a | b;
      4'b1100: r = ~(a | b) & mask;
      4'b0010: begin
        s = a + b; r = s & mask; cy = ((s >>> w) & 1) != 0;
        ov = ((a & msb) == (b & msb)) && ((r & msb) != (a & msb));
      end
      4'b0110: begin
        s = a + (~b & mask) + 1; r = s & mask; cy = ((s >>> w) & 1) != 0;
        ov = ((a & msb) != (b & msb)) && ((r & msb) != (a & msb));
      end
      default: begin
        sa_s = ((a & msb) != 0) ? a - (mask + 1) : a;
        sb_s = ((b & msb) != 0) ? b - (mask + 1) : b;
        r = (sa_s < sb_s) ? 1 : 0;
      end
    endcase
    return {cy, ov, (r == 0), r[31:0]};
  endfunction

  task automatic compare(input string tag, input logic [34:0] got, input logic [34:0] exp,
                         input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h actual c/v/z/res=%b/%b/%b/%h expected %b/%b/%b/%h",
               tag, op, a, b, got[34], got[33], got[32], got[31:0],
               exp[34], exp[33], exp[32], exp[31:0]);
    end
  endtask

  // tag picks R7/R8/R9 when only a flag differs
  function automatic string tag_for(input logic [3:0] op, input logic [34:0] got,
                                    input logic [34:0] exp);
    if (got[31:0] !== exp[31:0]) return op_req(op);
    if (got[32] !== exp[32]) return "R9";
    if (op == 4'b0010 || op == 4'b0110) return (got[33] !== exp[33]) ? "R7" : op_req(op);
    return "R8";
  endfunction

  task automatic run_small(input logic [3:0] op, input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [34:0] e, g;
    @(posedge clk);
    sop = op; sa = a; sb = b;
    @(negedge clk);
    e = ref_alu(op, longint'(a), longint'(b), SW);
    g = {sc, sv, sz, 28'd0, sres};
    compare(tag_for(op, g, e), g, e, 32'(a), 32'(b), op);
  endtask

  task automatic run_large(input logic [3:0] op, input logic [LW-1:0] a, input logic [LW-1:0] b);
    logic [34:0] e, g;
    @(posedge clk);
    lop = op; la = a; lb = b;
    @(negedge clk);
    e = ref_alu(op, longint'(a), longint'(b), LW);
    g = {lc, lv, lz, lres};
    compare(tag_for(op, g, e), g, e, a, b, op);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [4];
    corner[0] = 32'h7FFF_FFFF; corner[1] = 32'h8000_0000;
    corner[2] = 32'h0000_0000; corner[3] = 32'hFFFF_FFFF;
    sa = '0; sb = '0; sop = 4'b0000;
    la = '0; lb = '0; lop = 4'b0000;

    // initial state: AND of zeros -> zero result, zero flag set (R1, R9)
    @(negedge clk);
    compare("R9", {sc, sv, sz, 28'd0, sres}, {3'b001, 32'd0}, 32'd0, 32'd0, 4'b0000);
    compare("R9", {lc, lv, lz, lres}, {3'b001, 32'd0}, 32'd0, 32'd0, 4'b0000);

    // exhaustive 4-bit sweep: R1..R9
    for (int k = 0; k < 6; k++)
      for (int x = 0; x < (1 << SW); x++)
        for (int y = 0; y < (1 << SW); y++)
          run_small(op_code(k), SW'(x), SW'(y));

    // 32-bit corner pairings: overflow extremes R5 R7, full ripple R3 R4
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          run_large(op_code(k), corner[i], corner[j]);

    // 32-bit random operands, all codes
    for (int n = 0; n < 200; n++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (n % 10 == 0) rb = ra;
      for (int k = 0; k < 6; k++) run_large(op_code(k), ra, rb);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule